// File: doc/BRIEF.md
# Banked Cartridge ROM Page Decoder

This block sits between an 8-bit CPU with a 16-bit address bus and the memories of a cartridge system. It splits the lower 48KB of the address space into three 16KB windows. Each window shows a selectable 16KB page of cartridge ROM. The top 16KB is 8KB of system RAM, seen twice. For every bus cycle it reports which memory is addressed, the physical address inside that memory, and whether the write strobe reaches it.

Four page registers occupy the last four bytes of the address space. A CPU write to one of them loads the register, and the same write is still passed to system RAM. One register is a control byte. Its bit 3 replaces the ROM in the third window with writable cartridge RAM, and its bit 2 selects which of two 16KB RAM pages appears there. The lowest 1KB of the address space always shows the start of ROM, whatever page the first window selects. The mapper tracks whether cartridge RAM has been altered. The memory supplies the byte currently held at the addressed location, and a sticky flag is raised when a write stores a different value.

The decode is combinational from the address and the register state. The registers and the flag are clocked.

Top module: `cart_page_decoder`

## Requirements
- R1: After reset the control register is 0 and the window page registers hold 0, 1 and 2 for windows 0, 1 and 2, so the ROM pages seen are 0, 1 and 2. The dirty flag is 0 after reset.
- R2: Addresses 0x0000 to 0x03FF always decode to ROM (tgt = 0) at physical address equal to the CPU address, whatever is in the page registers.
- R3: Window 0 (0x0400 to 0x3FFF), window 1 (0x4000 to 0x7FFF) and window 2 (0x8000 to 0xBFFF) decode to ROM at physical address (page << 14) | addr[13:0]. The page comes from the register written at 0xFFFD, 0xFFFE or 0xFFFF respectively. A register write takes effect from the cycle after the write.
- R4: Each page number is reduced modulo ROM_BANKS, which is a power of two, by ANDing it with ROM_BANKS-1 before use. For example, page 17 with 16 banks addresses page 1.
- R5: When control bit 3 (written at 0xFFFC) is 1, window 2 decodes to cartridge RAM (tgt = 1) for reads and writes, at physical address (control bit 2 << 14) | addr[13:0].
- R6: Addresses 0xC000 to 0xFFFF decode to system RAM (tgt = 2) at physical address addr[12:0], with the write strobe following cpu_wr. This includes writes to the four page registers.
- R7: A write that decodes to ROM never raises mem_we.
- R8: A write that decodes to cartridge RAM with cpu_wdata different from cram_rdata sets the dirty flag from the next cycle on. A write of equal data leaves the flag unchanged, and so does any write that does not decode to cartridge RAM. Once set, the flag stays set until reset.
- R9: Control bits other than 2 and 3 have no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write cycle |
| cpu_wdata | input | 8 | CPU write data |
| cram_rdata | input | 8 | Byte currently stored in cartridge RAM at the decoded address |
| tgt | output | 2 | Target: 0 ROM, 1 cartridge RAM, 2 system RAM |
| phys_addr | output | PA_W (18) | Physical address within the target |
| mem_we | output | 1 | Write strobe to the target |
| dirty | output | 1 | Sticky flag: cartridge RAM content changed |

## Verification
The target, the physical address and the strobe depend only on the current address and on the register state, so they are due in the same cycle the address is presented. A page or control write, or a write that changes cartridge RAM, acts at the rising edge that ends that cycle. Its effect is therefore first visible on the following bus cycle. The bench drives each bus cycle at the falling edge and compares the outputs 5 ns later, before the next rising edge. Its model applies register and flag updates only after that comparison, which matches the one-edge latency.

// File: rtl/cart_page_pkg.sv
package cart_page_pkg;

    typedef enum logic [1:0] {
        TGT_ROM  = 2'd0,
        TGT_CRAM = 2'd1,
        TGT_SRAM = 2'd2
    } tgt_e;

    typedef struct packed {
        logic [7:0] ctl;
        logic [7:0] pg0;
        logic [7:0] pg1;
        logic [7:0] pg2;
    } page_regs_t;

    localparam int unsigned WIN_AW    = 14;
    localparam int unsigned SRAM_AW   = 13;
    localparam int unsigned FIXED_TOP = 16'h0400;
    localparam int unsigned CTL_RAMEN = 3;
    localparam int unsigned CTL_RAMPG = 2;

endpackage

// File: rtl/cart_page_regs.sv
module cart_page_regs
    import cart_page_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_wr,
    input  logic [7:0]  cpu_wdata,
    output page_regs_t  regs_q
);
    page_regs_t regs_d;
    logic       hit;

    always_comb begin
        hit    = cpu_wr && (cpu_addr[15:2] == 14'h3FFF);
        regs_d = regs_q;
        if (hit) begin
            case (cpu_addr[1:0])
                2'd0:    regs_d.ctl = cpu_wdata;
                2'd1:    regs_d.pg0 = cpu_wdata;
                2'd2:    regs_d.pg1 = cpu_wdata;
                default: regs_d.pg2 = cpu_wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.ctl <= 8'd0;
            regs_q.pg0 <= 8'd0;
            regs_q.pg1 <= 8'd1;
            regs_q.pg2 <= 8'd2;
        end else begin
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/cart_page_decode.sv
module cart_page_decode
    import cart_page_pkg::*;
#(
    parameter int unsigned RB_W = 4,
    parameter int unsigned PA_W = 18
) (
    input  logic [15:0]     cpu_addr,
    input  logic            cpu_wr,
    input  page_regs_t      regs,
    output tgt_e            tgt,
    output logic [PA_W-1:0] phys,
    output logic            we
);
    logic [7:0]      page_raw;
    logic [RB_W-1:0] page;
    logic [1:0]      win;

    always_comb begin
        win = cpu_addr[15:14];
        case (win)
            2'd0:    page_raw = regs.pg0;
            2'd1:    page_raw = regs.pg1;
            default: page_raw = regs.pg2;
        endcase
        page = page_raw[RB_W-1:0];

        tgt  = TGT_ROM;
        phys = PA_W'({page, cpu_addr[WIN_AW-1:0]});
        we   = 1'b0;

        if (win == 2'd3) begin
            tgt  = TGT_SRAM;
            phys = PA_W'(cpu_addr[SRAM_AW-1:0]);
            we   = cpu_wr;
        end else if (32'(cpu_addr) < FIXED_TOP) begin
            tgt  = TGT_ROM;
            phys = PA_W'(cpu_addr);
        end else if (win == 2'd2 && regs.ctl[CTL_RAMEN]) begin
            tgt  = TGT_CRAM;
            phys = PA_W'({regs.ctl[CTL_RAMPG], cpu_addr[WIN_AW-1:0]});
            we   = cpu_wr;
        end
    end
endmodule

// File: rtl/cart_dirty_track.sv
module cart_dirty_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cram_wr,
    input  logic [7:0] wdata,
    input  logic [7:0] rdata,
    output logic       dirty_q
);
    logic dirty_d;

    always_comb begin
        dirty_d = dirty_q;
        if (cram_wr && (wdata != rdata))
            dirty_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dirty_q <= 1'b0;
        else        dirty_q <= dirty_d;
    end
endmodule

// File: rtl/cart_page_decoder.sv
module cart_page_decoder
    import cart_page_pkg::*;
#(
    parameter int unsigned ROM_BANKS = 16,
    localparam int unsigned RB_W = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1,
    localparam int unsigned PA_W = (RB_W + WIN_AW > WIN_AW + 1) ? RB_W + WIN_AW : WIN_AW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [15:0]     cpu_addr,
    input  logic            cpu_wr,
    input  logic [7:0]      cpu_wdata,
    input  logic [7:0]      cram_rdata,
    output logic [1:0]      tgt,
    output logic [PA_W-1:0] phys_addr,
    output logic            mem_we,
    output logic            dirty
);
    page_regs_t regs_q;
    tgt_e       tgt_w;

    cart_page_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .regs_q    (regs_q)
    );

    cart_page_decode #(.RB_W(RB_W), .PA_W(PA_W)) u_dec (
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .regs     (regs_q),
        .tgt      (tgt_w),
        .phys     (phys_addr),
        .we       (mem_we)
    );

    cart_dirty_track u_dirty (
        .clk     (clk),
        .rst_n   (rst_n),
        .cram_wr (mem_we && (tgt_w == TGT_CRAM)),
        .wdata   (cpu_wdata),
        .rdata   (cram_rdata),
        .dirty_q (dirty)
    );

    assign tgt = tgt_w;
endmodule

// File: rtl/cart_page_decoder_chk.sv
module cart_page_decoder_chk #(
    parameter int unsigned PA_W = 18
) (
    input logic            clk,
    input logic            rst_n,
    input logic [15:0]     cpu_addr,
    input logic            cpu_wr,
    input logic [1:0]      tgt,
    input logic [PA_W-1:0] phys_addr,
    input logic            mem_we,
    input logic            dirty
);
    // R2
    low_kb_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < 16'h0400) |-> (tgt == 2'd0 && phys_addr == PA_W'(cpu_addr)));

    // R6
    sys_ram_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b11) |-> (tgt == 2'd2 && phys_addr == PA_W'(cpu_addr[12:0])
                                        && mem_we == cpu_wr));

    // R7
    rom_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == 2'd0) |-> !mem_we);

    // R5
    cram_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == 2'd1) |-> (cpu_addr[15:14] == 2'b10 && phys_addr[13:0] == cpu_addr[13:0]));

    // R8
    dirty_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dirty |=> dirty);
endmodule

bind cart_page_decoder cart_page_decoder_chk #(.PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .tgt       (tgt),
    .phys_addr (phys_addr),
    .mem_we    (mem_we),
    .dirty     (dirty)
);

// File: tb/tb_cart_page_decoder.sv
module tb_cart_page_decoder;
    localparam int NB   = 16;
    localparam int PA_W = 18;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [15:0]     cpu_addr = 16'h0;
    logic            cpu_wr = 1'b0;
    logic [7:0]      cpu_wdata = 8'h0;
    logic [7:0]      cram_rdata = 8'h0;
    logic [1:0]      tgt;
    logic [PA_W-1:0] phys_addr;
    logic            mem_we;
    logic            dirty;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    int m_ctl, m_p0, m_p1, m_p2;
    bit m_dirty;

    always #10 clk = ~clk;

    cart_page_decoder #(.ROM_BANKS(NB)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cram_rdata(cram_rdata), .tgt(tgt),
        .phys_addr(phys_addr), .mem_we(mem_we), .dirty(dirty)
    );

    task automatic model_reset();
        m_ctl = 0; m_p0 = 0; m_p1 = 1; m_p2 = 2; m_dirty = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cpu_wr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // one bus cycle: drive at falling edge, compare, let the rising edge act
    task automatic step(input int a, input bit w, input int wd, input int rd, input string tag);
        int et, ep, page;
        bit ew;
        string lbl;
        @(negedge clk);
        cpu_addr = 16'(a); cpu_wr = w; cpu_wdata = 8'(wd); cram_rdata = 8'(rd);
        #5;
        lbl = tag;
        if (a >= 16'hC000) begin
            et = 2; ep = a % 8192; ew = w;
            if (lbl == "") lbl = "R6";
        end else if (a < 16'h0400) begin
            et = 0; ep = a; ew = 0;
            if (lbl == "") lbl = "R2";
        end else if (a >= 16'h8000 && ((m_ctl / 8) % 2 == 1)) begin
            et = 1; ep = ((m_ctl / 4) % 2) * 16384 + (a % 16384); ew = w;
            if (lbl == "") lbl = "R5";
        end else begin
            page = (a < 16'h4000) ? m_p0 : (a < 16'h8000) ? m_p1 : m_p2;
            et = 0; ep = (page % NB) * 16384 + (a % 16384); ew = 0;
            if (lbl == "") begin
                if (w) lbl = "R7";
                else if (a >= 16'h8000 && (m_ctl & 8'hF3) != 0) lbl = "R9";
                else if (page >= NB) lbl = "R4";
                else lbl = "R3";
            end
        end
        n_cmp++;
        if (int'(tgt) != et || int'(phys_addr) != ep || mem_we != ew || dirty != m_dirty) begin
            n_bad++;
            $display("FAIL %s addr=%h: tgt=%0d phys=%h we=%0b dirty=%0b expected tgt=%0d phys=%h we=%0b dirty=%0b",
                     lbl, a, tgt, phys_addr, mem_we, dirty, et, ep, ew, m_dirty);
        end
        if (w && a >= 16'hFFFC) begin
            case (a % 4)
                0: m_ctl = wd;
                1: m_p0 = wd;
                2: m_p1 = wd;
                default: m_p2 = wd;
            endcase
        end
        if (w && et == 1 && wd != rd) m_dirty = 1;
        @(posedge clk);
        #1 cpu_wr = 1'b0;
    endtask

    task automatic sweep(input int seed, input string tag);
        for (int pg = 0; pg < 256; pg++) begin
            step(pg * 256, 1'b0, 0, 0, tag);
            step(pg * 256 + 255, pg % 2 == 1, (pg ^ seed) % 256, (pg ^ seed) % 256, tag);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        // R1: reset page registers and flag, then the whole space
        step(16'h0400, 1'b0, 0, 0, "R1");
        step(16'h4000, 1'b0, 0, 0, "R1");
        step(16'hBFFF, 1'b0, 0, 0, "R1");
        sweep(0, "R1");

        // page values past the bank count exercise masking (R4)
        for (int v = 0; v < 32; v++) begin
            int c;
            case (v % 5)
                0: c = 8'h00;
                1: c = 8'h08;
                2: c = 8'h0C;
                3: c = 8'hF3;
                default: c = 8'hF7;
            endcase
            step(16'hFFFC, 1'b1, c, 0, "R6");
            step(16'hFFFD, 1'b1, v, 0, "R6");
            step(16'hFFFE, 1'b1, (v + 5) % 256, 0, "R6");
            step(16'hFFFF, 1'b1, (v * 7 + 2) % 256, 0, "R6");
            step(16'h03FF, 1'b0, 0, 0, "R2");
            step(16'h0400, 1'b0, 0, 0, "R3");
            sweep(v, "");
        end

        // R8: dirty tracking
        do_reset();
        step(16'h8000, 1'b1, 8'h12, 8'h34, "R8");   // ROM target, no effect
        step(16'hC123, 1'b1, 8'h12, 8'h34, "R8");   // system RAM, no effect
        step(16'hFFFC, 1'b1, 8'h08, 0, "R8");
        step(16'h8000, 1'b1, 8'h55, 8'h55, "R8");   // equal data
        step(16'h8001, 1'b0, 8'h00, 8'h11, "R8");
        step(16'hBFFF, 1'b1, 8'h12, 8'h34, "R8");   // change
        step(16'h8002, 1'b0, 0, 0, "R8");
        step(16'hFFFC, 1'b1, 8'h00, 0, "R8");
        for (int k = 0; k < 8; k++) step(16'h9000 + k, 1'b1, k, k, "R8");
        do_reset();
        step(16'h8000, 1'b0, 0, 0, "R8");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule